// File: doc/BRIEF.md
# Saturating Hit and Miss Event Counters

This block keeps two performance counters beside a cache lookup pipeline. The lookup logic sends one single-cycle strobe for each hit and one for each miss. The block counts each kind of event in its own counter. The hit counter is wider than the miss counter, and neither counter wraps: once a counter is full it stays at its top value until software clears it.

Software drives the block through a small register port. One control word holds an enable bit and a clear bit for each counter. Each clear bit sits two positions above the enable bit of the same counter. To zero a counter, software writes its clear bit to 1 and then writes it back to 0. While the clear bit is 1, the counter is held at zero. Both counters can be enabled or cleared with a single write. The control word and both counts can be read back over the same port. The counts are also available on dedicated output pins.

Top module: `evt_monitor`

## Requirements
- R1: The hit counter is HIT_W bits wide (default 32). Each cycle with `hit_evt` high, while counting is enabled and the clear bit is low, raises it by exactly one on the next clock edge.
- R2: When the hit counter is all ones, further hit strobes leave it at all ones. It never wraps to zero.
- R3: The miss counter is MISS_W bits wide (default 16). Each cycle with `miss_evt` high, while counting is enabled and the clear bit is low, raises it by exactly one on the next clock edge.
- R4: When the miss counter is all ones, further miss strobes leave it at all ones.
- R5: Control word layout, at address 0: bit 0 enables hit counting and bit 1 enables miss counting. A counter whose enable bit is 0 ignores its strobe, and its value stays unchanged.
- R6: Bit 2 of the control word clears the hit counter and bit 3 clears the miss counter. While a clear bit is 1, its counter reads zero one edge later and counts no events. After the bit returns to 0, counting restarts from zero.
- R7: After the synchronous active-high `rst`, both counters and the control word are zero.
- R8: A hit strobe and a miss strobe in the same cycle are each counted, in their own counter, on the same edge.
- R9: Readback: `cfg_rdata` is registered and shows, one edge after `cfg_addr` is presented, the following value for each address:
  - address 0: the control word;
  - address 1: the hit count, zero-extended;
  - address 2: the miss count, zero-extended;
  - address 3: zero.
- R10: A single write with `cfg_wr` high at address 0 updates all four control bits at once. Setting both enable bits, or both clear bits, in one write affects both counters together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hit_evt | input | 1 | One-cycle hit strobe from the lookup logic |
| miss_evt | input | 1 | One-cycle miss strobe from the lookup logic |
| cfg_wr | input | 1 | Write strobe for the control word |
| cfg_addr | input | 2 | Register address for write and readback |
| cfg_wdata | input | 4 | Control word write data |
| cfg_rdata | output | DATA_W | Registered readback data |
| hit_count | output | HIT_W | Hit counter value |
| miss_count | output | MISS_W | Miss counter value |

## Verification
Two functions can fall in the same cycle:
- a hit strobe and a miss strobe, which must each land in their own counter on one edge;
- an event strobe and an asserted clear bit, where the clear must win.

The bench runs on a reduced configuration (6-bit hit counter, 4-bit miss counter) so that saturation is reached quickly. For each of the sixteen control words, it applies every one of the four strobe combinations. After every edge it compares both counts with an arithmetic model of increment, saturation, enable gating and clear hold.

// File: rtl/evt_monitor_pkg.sv
package evt_monitor_pkg;

  localparam int CTRL_W = 4;
  localparam int ADDR_W = 2;

  // Clear bits sit two positions above the enable bit of the same counter.
  typedef struct packed {
    logic miss_clr;  // bit 3
    logic hit_clr;   // bit 2
    logic miss_en;   // bit 1
    logic hit_en;    // bit 0
  } ctrl_t;

  localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] A_HIT  = 2'd1;
  localparam logic [ADDR_W-1:0] A_MISS = 2'd2;

endpackage

// File: rtl/evt_ctrl_reg.sv
module evt_ctrl_reg
  import evt_monitor_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CTRL_W-1:0] wdata,
  output ctrl_t             ctrl
);

  logic sel;
  assign sel = wr && (addr == A_CTRL);

  always_ff @(posedge clk) begin
    if (rst) ctrl <= '0;
    else if (sel) ctrl <= ctrl_t'(wdata);
  end

  // R10: one write lands all four control bits together.
  p_ctrl_write_r10: assert property (@(posedge clk) disable iff (rst)
    (wr && addr == A_CTRL) |=> (ctrl == ctrl_t'($past(wdata))));

  // Without a write to the control address, the control word holds.
  p_ctrl_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !(wr && addr == A_CTRL) |=> $stable(ctrl));

endmodule

// File: rtl/evt_sat_counter.sv
module evt_sat_counter #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          en,
  input  logic          evt,
  output logic [CW-1:0] cnt
);

  localparam logic [CW-1:0] TOP = {CW{1'b1}};

  logic full;
  logic bump;

  assign full = (cnt == TOP);
  assign bump = en && evt && !full;

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (bump) cnt <= cnt + 1'b1;
  end

  // R1/R3: an accepted event raises the count by exactly one.
  p_step_r1: assert property (@(posedge clk) disable iff (rst)
    (!clr && en && evt && cnt != TOP) |=> (cnt == CW'($past(cnt) + 1'b1)));

  // R2/R4: a full counter stays full.
  p_no_wrap_r2: assert property (@(posedge clk) disable iff (rst)
    (!clr && cnt == TOP) |=> (cnt == TOP));

  // R5: a disabled counter keeps its value.
  p_idle_r5: assert property (@(posedge clk) disable iff (rst)
    (!clr && !en) |=> $stable(cnt));

  // R6: a clear bit forces zero on the next edge, whatever the strobe.
  p_clear_r6: assert property (@(posedge clk) disable iff (rst)
    clr |=> (cnt == '0));

  // Without an event the count never moves except by clearing.
  p_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    (!clr && !evt) |=> $stable(cnt));

endmodule

// File: rtl/evt_readback.sv
module evt_readback
  import evt_monitor_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int HIT_W  = 32,
  parameter int MISS_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  ctrl_t             ctrl,
  input  logic [HIT_W-1:0]  hit_cnt,
  input  logic [MISS_W-1:0] miss_cnt,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] sel_val;

  always_comb begin
    unique case (addr)
      A_CTRL:  sel_val = DATA_W'(ctrl);
      A_HIT:   sel_val = DATA_W'(hit_cnt);
      A_MISS:  sel_val = DATA_W'(miss_cnt);
      default: sel_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else rdata <= sel_val;
  end

  // R9: unmapped addresses read as zero.
  p_unmapped_r9: assert property (@(posedge clk) disable iff (rst)
    (addr == 2'd3) |=> (rdata == '0));

endmodule

// File: rtl/evt_monitor.sv
module evt_monitor
  import evt_monitor_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int HIT_W  = 32,
  parameter int MISS_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hit_evt,
  input  logic              miss_evt,
  input  logic              cfg_wr,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [CTRL_W-1:0] cfg_wdata,
  output logic [DATA_W-1:0] cfg_rdata,
  output logic [HIT_W-1:0]  hit_count,
  output logic [MISS_W-1:0] miss_count
);

  ctrl_t ctrl;

  evt_ctrl_reg u_ctrl (
    .clk   (clk),
    .rst   (rst),
    .wr    (cfg_wr),
    .addr  (cfg_addr),
    .wdata (cfg_wdata),
    .ctrl  (ctrl)
  );

  evt_sat_counter #(.CW(HIT_W)) u_hit (
    .clk (clk),
    .rst (rst),
    .clr (ctrl.hit_clr),
    .en  (ctrl.hit_en),
    .evt (hit_evt),
    .cnt (hit_count)
  );

  evt_sat_counter #(.CW(MISS_W)) u_miss (
    .clk (clk),
    .rst (rst),
    .clr (ctrl.miss_clr),
    .en  (ctrl.miss_en),
    .evt (miss_evt),
    .cnt (miss_count)
  );

  evt_readback #(.DATA_W(DATA_W), .HIT_W(HIT_W), .MISS_W(MISS_W)) u_rb (
    .clk      (clk),
    .rst      (rst),
    .addr     (cfg_addr),
    .ctrl     (ctrl),
    .hit_cnt  (hit_count),
    .miss_cnt (miss_count),
    .rdata    (cfg_rdata)
  );

  // R8: simultaneous strobes advance both unsaturated, enabled counters.
  p_pair_r8: assert property (@(posedge clk) disable iff (rst)
    (hit_evt && miss_evt && ctrl.hit_en && ctrl.miss_en &&
     !ctrl.hit_clr && !ctrl.miss_clr &&
     !(&hit_count) && !(&miss_count))
    |=> (hit_count != $past(hit_count)) && (miss_count != $past(miss_count)));

  // R6: a miss strobe never disturbs the hit counter.
  p_isolate_r6: assert property (@(posedge clk) disable iff (rst)
    (!hit_evt && !ctrl.hit_clr) |=> $stable(hit_count));

endmodule

// File: tb/sim_evt_monitor.sv
module sim_evt_monitor;
  localparam int HW = 6;
  localparam int MW = 4;
  localparam int DW = 32;
  localparam int HMAX = (1 << HW) - 1;
  localparam int MMAX = (1 << MW) - 1;

  logic clk = 0;
  logic rst = 1;
  logic hit_evt = 0, miss_evt = 0, cfg_wr = 0;
  logic [1:0] cfg_addr = 0;
  logic [3:0] cfg_wdata = 0;
  logic [DW-1:0] cfg_rdata;
  logic [HW-1:0] hit_count;
  logic [MW-1:0] miss_count;

  int checks = 0, fails = 0, cycles = 0;
  int eh = 0, em = 0;
  logic [3:0] ec = 0;
  bit done = 0;

  always #10 clk = ~clk;

  evt_monitor #(.DATA_W(DW), .HIT_W(HW), .MISS_W(MW)) u0 (
    .clk(clk), .rst(rst), .hit_evt(hit_evt), .miss_evt(miss_evt),
    .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .hit_count(hit_count), .miss_count(miss_count)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Model of one clock edge with the given strobes and current control.
  task automatic model_edge(input bit h, input bit m);
    if (ec[2]) eh = 0; else if (ec[0] && h && eh < HMAX) eh++;
    if (ec[3]) em = 0; else if (ec[1] && m && em < MMAX) em++;
  endtask

  task automatic step(input bit h, input bit m);
    hit_evt = h; miss_evt = m;
    @(negedge clk);
    hit_evt = 0; miss_evt = 0;
    model_edge(h, m);
  endtask

  task automatic wr_ctrl(input logic [3:0] v);
    cfg_wr = 1; cfg_addr = 2'd0; cfg_wdata = v;
    @(negedge clk);
    cfg_wr = 0;
    model_edge(0, 0);
    ec = v;
  endtask

  task automatic counts(input string rh, input string rm);
    chk(rh, hit_count, eh);
    chk(rm, miss_count, em);
  endtask

  task automatic rd(input logic [1:0] a, input int exp, input string req);
    cfg_addr = a;
    step(0, 0);
    chk(req, cfg_rdata, exp);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=finish", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk);
    rst = 0;
    // R7: reset state
    counts("R7 hit", "R7 miss");
    rd(2'd0, 0, "R7 ctrl");
    // R5: disabled counters ignore strobes
    for (int i = 0; i < 5; i++) step(1, 1);
    counts("R5 hit", "R5 miss");
    // R10: both enables in one write
    wr_ctrl(4'h3);
    rd(2'd0, 3, "R10 ctrl");
    for (int i = 0; i < 5; i++) step(1, 0);
    counts("R1 hit", "R1 miss");
    for (int i = 0; i < 3; i++) step(0, 1);
    counts("R3 hit", "R3 miss");
    for (int i = 0; i < 4; i++) begin
      step(1, 1);
      counts("R8 hit", "R8 miss");
    end
    // R2/R4: count past saturation
    for (int i = 0; i < HMAX + 6; i++) begin
      step(1, 1);
      chk("R2 hit", hit_count, eh);
      chk("R4 miss", miss_count, em);
    end
    chk("R2 full", hit_count, HMAX);
    chk("R4 full", miss_count, MMAX);
    // R9: readback map
    rd(2'd1, HMAX, "R9 hit");
    rd(2'd2, MMAX, "R9 miss");
    rd(2'd3, 0, "R9 unmapped");
    // R6: hit clear held, miss continues
    wr_ctrl(4'h7);
    for (int i = 0; i < 3; i++) step(1, 1);
    chk("R6 hit held", hit_count, 0);
    chk("R6 miss", miss_count, em);
    wr_ctrl(4'h3);
    step(1, 0);
    chk("R6 restart", hit_count, 1);
    // R10: clear both in one write
    wr_ctrl(4'hF);
    step(1, 1);
    counts("R10 hit clr", "R10 miss clr");
    wr_ctrl(4'h0);
    // Sweep all control words and strobe pairs
    for (int v = 0; v < 16; v++) begin
      wr_ctrl(4'(v));
      rd(2'd0, v, "R10 sweep ctrl");
      for (int k = 0; k < 4; k++) begin
        step(k[0], k[1]);
        counts("R6 sweep hit", "R6 sweep miss");
      end
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule